// File: doc/BRIEF.md
# Dual Maskable Time-of-Day Alarm Unit

This block holds two independent time-of-day alarms and compares each one against the current calendar time once per second. Each alarm has four byte-wide registers: seconds, minutes, hours and day. The most significant bit of each register is a mask that removes that field from the comparison. The low seven bits hold the value to match.

Masking fields from the day end downwards sets how often an alarm fires. With no masks set, it fires once a week. With only the day masked, it fires once a day. With day and hour masked, it fires once an hour. With day, hour and minute masked, it fires once a minute. With all four masked, it fires every second.

A match raises a sticky per-alarm flag. The flag stays set until software clears it. A small control register holds one interrupt enable per alarm and a routing bit. The routing bit decides whether each alarm drives its own active-low interrupt line, or whether both alarms share the first line. A timekeeping counter supplies the time fields and a one-second strobe that is raised after those fields have updated.

Top module: `tod_alarm_unit`

## Requirements
- R1: While reset is asserted and after it is released, all alarm registers, the control register and both flags are zero, and both interrupt outputs are high.
- R2: A write to address 87h, 88h, 89h or 8Ah loads the seconds, minutes, hours or day register of alarm 0, in that order. Addresses 8Bh to 8Eh load the same four registers of alarm 1 in the same order. A write to any other address except 8Fh changes no alarm register.
- R3: A write to 8Fh loads the control register from data bits 2:0. Bit 0 enables alarm 0 and bit 1 enables alarm 1. Bit 2 selects the routing: 1 means each alarm has its own line, 0 means both alarms share the first line.
- R4: An alarm is compared only in a cycle in which the one-second strobe is high. A time that matches while the strobe is low sets no flag.
- R5: Bit 7 of each alarm register is a mask that excludes that field from the comparison. An unmasked field matches when its bits 6:0 equal the current time field.
- R6: With all masks clear, the flag is set only when seconds, minutes, hours and day all match.
- R7: With all four masks set, every strobe sets the flag.
- R8: A flag stays set until its clear input is high. When a match and a clear arrive in the same cycle, the flag ends that cycle set.
- R9: With routing bit 1, the first output is low exactly when flag 0 and enable 0 are both set, and the second output is low exactly when flag 1 and enable 1 are both set.
- R10: With routing bit 0, the first output is low when either alarm has its flag and its enable set, and the second output stays high.
- R11: Clearing an enable hides the interrupt but keeps the flag. Setting the enable again brings the interrupt back without a new match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| now_sec | input | 7 | Current seconds field |
| now_min | input | 7 | Current minutes field |
| now_hour | input | 7 | Current hours field |
| now_day | input | 7 | Current day field |
| tick_1hz | input | 1 | One-second strobe, raised after the time fields have updated |
| flag_clr | input | 2 | Per-alarm flag clear, bit n clears alarm n |
| irq_a_n | output | 1 | First interrupt line, active low |
| irq_b_n | output | 1 | Second interrupt line, active low |

## Verification
The bench builds the unit with its default alarm base address (87h) and control address (8Fh), so the address decoding it checks is the real layout.

Directed sequences step through each mask rate and both routing settings. They also cover a match and a clear arriving in the same cycle, and an enable being cleared and set again.

A long random phase follows. It keeps the time fields and the alarm values in a narrow range, so matches happen often. It also writes to addresses on both sides of the alarm window. The outputs are compared on every clock against a behavioural model.

// File: rtl/tod_alarm_pkg.sv
// Package: shared sizes and addresses for the dual time-of-day alarm unit.
// Assumes byte-wide registers with a mask in the top bit and a 7-bit value.
package tod_alarm_pkg;
    localparam int NUM_ALARMS = 2;
    localparam int NUM_FIELDS = 4;   // seconds, minutes, hours, day
    localparam int REG_W      = 8;
    localparam int CMP_W      = REG_W - 1;
    localparam int MASK_BIT   = REG_W - 1;
    localparam int ADDR_W     = 8;
    localparam int CTRL_W     = 3;
    localparam int SEP_BIT    = 2;

    typedef logic [NUM_FIELDS-1:0][REG_W-1:0] alarm_regs_t;
    typedef logic [NUM_FIELDS-1:0][CMP_W-1:0] tod_fields_t;
endpackage

// File: rtl/tod_alarm_regs.sv
// Module: register bank for one alarm (four fields, index 0 = seconds).
// Assumes the fields sit at consecutive addresses starting at BASE.
module tod_alarm_regs
    import tod_alarm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = 8'h87
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output alarm_regs_t       regs_o
);
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(BASE) + f);

        // Load this field when its own address is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_o[f] <= '0;
            else if (wr_en_i && wr_addr_i == MY_ADDR)
                regs_o[f] <= wr_data_i;
        end

        // R2: a write to this address is visible on the next cycle.
        a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_addr_i == MY_ADDR) |=> (regs_o[f] == $past(wr_data_i)));
    end
endmodule

// File: rtl/tod_alarm_match.sv
// Module: masked comparator and sticky flag for one alarm.
// Assumes the time fields are already updated when the strobe is high.
module tod_alarm_match
    import tod_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  alarm_regs_t regs_i,
    input  tod_fields_t now_i,
    input  logic        tick_i,
    input  logic        clr_i,
    output logic        flag_o
);
    logic [NUM_FIELDS-1:0] field_hit;
    logic                  all_hit;

    // A field hits when it is masked or its value equals the time field.
    always_comb begin
        for (int f = 0; f < NUM_FIELDS; f++)
            field_hit[f] = regs_i[f][MASK_BIT] || (regs_i[f][CMP_W-1:0] == now_i[f]);
        all_hit = &field_hit;
    end

    // The flag is set on a strobe with a match, and kept until it is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (tick_i && all_hit)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    // R4: without a strobe, a clear flag stays clear.
    a_r4_no_set_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !tick_i) |=> !flag_o);
    // R8: without a clear, a set flag stays set.
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    // R7: with all masks set, a strobe always sets the flag.
    a_r7_all_masked_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && regs_i[0][MASK_BIT] && regs_i[1][MASK_BIT]
         && regs_i[2][MASK_BIT] && regs_i[3][MASK_BIT]) |=> flag_o);
endmodule

// File: rtl/tod_alarm_irq.sv
// Module: control register (enables and routing) and interrupt output mux.
// Assumes exactly two alarms; the routing bit merges both onto line A.
module tod_alarm_irq
    import tod_alarm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [CTRL_W-1:0]     wr_data_i,
    input  logic [NUM_ALARMS-1:0] flags_i,
    output logic                  irq_a_n,
    output logic                  irq_b_n
);
    logic [CTRL_W-1:0]     ctrl_q;
    logic [NUM_ALARMS-1:0] active;
    logic                  sep_mode;

    // Load the control bits when the control address is written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_en_i && wr_addr_i == CTRL_ADDR)
            ctrl_q <= wr_data_i;
    end

    // Route the enabled flags to the two active-low lines.
    always_comb begin
        active   = flags_i & ctrl_q[NUM_ALARMS-1:0];
        sep_mode = ctrl_q[SEP_BIT];
        if (sep_mode) begin
            irq_a_n = !active[0];
            irq_b_n = !active[1];
        end else begin
            irq_a_n = !(|active);
            irq_b_n = 1'b1;
        end
    end

    // R10: line B is idle while the routing is merged.
    a_r10_b_idle_merged: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[SEP_BIT] |-> irq_b_n);
    // R9: line B only falls for a flagged alarm 1.
    a_r9_b_needs_flag1: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_b_n |-> flags_i[1]);
    // R11: any low line implies some flag is still held.
    a_r11_low_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_a_n |-> (|flags_i));
endmodule

// File: rtl/tod_alarm_unit.sv
// Module: top of the dual time-of-day alarm unit.
// Assumes alarm n fields start at ALARM_BASE + 4*n and a one-cycle strobe.
module tod_alarm_unit
    import tod_alarm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ALARM_BASE = 8'h87,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'h8F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [REG_W-1:0]      wr_data,
    input  logic [CMP_W-1:0]      now_sec,
    input  logic [CMP_W-1:0]      now_min,
    input  logic [CMP_W-1:0]      now_hour,
    input  logic [CMP_W-1:0]      now_day,
    input  logic                  tick_1hz,
    input  logic [NUM_ALARMS-1:0] flag_clr,
    output logic                  irq_a_n,
    output logic                  irq_b_n
);
    tod_fields_t           now_fields;
    logic [NUM_ALARMS-1:0] flags;

    assign now_fields = {now_day, now_hour, now_min, now_sec};

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(int'(ALARM_BASE) + a * NUM_FIELDS);
        alarm_regs_t regs;

        tod_alarm_regs #(.BASE(BASE_A)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en_i   (wr_en),
            .wr_addr_i (wr_addr),
            .wr_data_i (wr_data),
            .regs_o    (regs)
        );

        tod_alarm_match u_match (
            .clk    (clk),
            .rst_n  (rst_n),
            .regs_i (regs),
            .now_i  (now_fields),
            .tick_i (tick_1hz),
            .clr_i  (flag_clr[a]),
            .flag_o (flags[a])
        );
    end

    tod_alarm_irq #(.CTRL_ADDR(CTRL_ADDR)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data[CTRL_W-1:0]),
        .flags_i   (flags),
        .irq_a_n   (irq_a_n),
        .irq_b_n   (irq_b_n)
    );
endmodule

// File: tb/tod_alarm_unit_test.sv
`timescale 1ns/1ps
module tod_alarm_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [6:0] now_sec = '0, now_min = '0, now_hour = '0, now_day = '0;
    logic       tick_1hz = 1'b0;
    logic [1:0] flag_clr = 2'b00;
    logic       irq_a_n, irq_b_n;

    int checks = 0;
    int fails  = 0;
    bit model_on = 1'b0;

    // Reference model state.
    logic [7:0] m_reg [2][4];
    logic [2:0] m_ctrl;
    logic       m_flag [2];
    logic [6:0] nv [4];
    bit         hit;

    always #2 clk = ~clk;

    tod_alarm_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_day(now_day),
        .tick_1hz(tick_1hz), .flag_clr(flag_clr), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
    );

    // Model update: compare with old registers, then apply the write.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 2; a++) begin
                m_flag[a] = 1'b0;
                for (int f = 0; f < 4; f++) m_reg[a][f] = 8'h00;
            end
            m_ctrl = 3'b000;
        end else begin
            nv[0] = now_sec; nv[1] = now_min; nv[2] = now_hour; nv[3] = now_day;
            for (int a = 0; a < 2; a++) begin
                hit = 1'b1;
                for (int f = 0; f < 4; f++)
                    if (!m_reg[a][f][7] && m_reg[a][f][6:0] != nv[f]) hit = 1'b0;
                if (tick_1hz && hit) m_flag[a] = 1'b1;
                else if (flag_clr[a]) m_flag[a] = 1'b0;
            end
            if (wr_en) begin
                if (wr_addr >= 8'h87 && wr_addr <= 8'h8E)
                    m_reg[(wr_addr - 8'h87) / 4][(wr_addr - 8'h87) % 4] = wr_data;
                else if (wr_addr == 8'h8F)
                    m_ctrl = wr_data[2:0];
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Compare both lines with the model between edges.
    always @(negedge clk) begin
        if (model_on) begin
            logic e0, e1, ea, eb;
            e0 = m_flag[0] & m_ctrl[0];
            e1 = m_flag[1] & m_ctrl[1];
            ea = m_ctrl[2] ? !e0 : !(e0 | e1);
            eb = m_ctrl[2] ? !e1 : 1'b1;
            chk("R9 R10 model line A", irq_a_n, ea);
            chk("R9 R10 model line B", irq_b_n, eb);
        end
    end

    task automatic wr(input logic [7:0] ad, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = ad; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic set_now(input int s, input int m, input int h, input int d);
        now_sec = 7'(s); now_min = 7'(m); now_hour = 7'(h); now_day = 7'(d);
    endtask

    task automatic tick(input int s, input int m, input int h, input int d);
        @(negedge clk); set_now(s, m, h, d); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic clr(input logic [1:0] c);
        @(negedge clk); flag_clr = c;
        @(negedge clk); flag_clr = 2'b00;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset line A", irq_a_n, 1'b1);
        chk("R1 reset line B", irq_b_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        model_on = 1'b1;
        chk("R1 after reset line A", irq_a_n, 1'b1);

        wr(8'h8F, 8'h07);                                          // R3: separate, both on
        wr(8'h87, 8'h10); wr(8'h88, 8'h20); wr(8'h89, 8'h03); wr(8'h8A, 8'h02); // R2
        tick(16, 32, 3, 1);
        chk("R6 day mismatch", irq_a_n, 1'b1);
        tick(16, 32, 3, 2);
        chk("R6 full match", irq_a_n, 1'b0);
        chk("R9 line B idle", irq_b_n, 1'b1);
        clr(2'b01);
        chk("R8 clear", irq_a_n, 1'b1);
        @(negedge clk); set_now(16, 32, 3, 2);
        repeat (3) @(negedge clk);
        chk("R4 match without strobe", irq_a_n, 1'b1);
        tick(16, 32, 3, 2); tick(0, 0, 0, 0);
        chk("R8 sticky after mismatch", irq_a_n, 1'b0);
        @(negedge clk); set_now(16, 32, 3, 2); tick_1hz = 1'b1; flag_clr = 2'b01;
        @(negedge clk); tick_1hz = 1'b0; flag_clr = 2'b00;
        chk("R8 match beats clear", irq_a_n, 1'b0);
        clr(2'b01);

        wr(8'h8A, 8'h82);                                          // R5: day masked
        tick(16, 32, 3, 5);
        chk("R5 daily with day masked", irq_a_n, 1'b0);
        clr(2'b01);
        wr(8'h89, 8'h83);                                          // hour masked too
        tick(16, 32, 9, 6);
        chk("R5 hourly with day and hour masked", irq_a_n, 1'b0);
        clr(2'b01);
        tick(17, 32, 9, 6);
        chk("R5 unmasked seconds mismatch", irq_a_n, 1'b1);

        wr(8'h8B, 8'h80); wr(8'h8C, 8'h80); wr(8'h8D, 8'h80); wr(8'h8E, 8'h80);
        tick(5, 6, 7, 1);
        chk("R7 all masked fires", irq_b_n, 1'b0);
        chk("R9 separate line A stays high", irq_a_n, 1'b1);
        clr(2'b10);
        tick(44, 1, 2, 3);
        chk("R7 fires again", irq_b_n, 1'b0);

        wr(8'h8F, 8'h03);                                          // merged
        chk("R10 alarm 1 on line A", irq_a_n, 1'b0);
        chk("R10 line B idle", irq_b_n, 1'b1);
        wr(8'h8F, 8'h04);                                          // enables off
        chk("R11 hidden line B", irq_b_n, 1'b1);
        wr(8'h8F, 8'h06);
        chk("R11 restored line B", irq_b_n, 1'b0);
        wr(8'h86, 8'h00); wr(8'h90, 8'h00);
        chk("R2 outside writes ignored", irq_b_n, 1'b0);
        clr(2'b11);

        // Random phase, narrow ranges so matches are frequent.
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            wr_en = ($urandom_range(0, 3) == 0);
            wr_addr = 8'($urandom_range(8'h85, 8'h90));
            wr_data = {($urandom_range(0, 2) == 0), 7'($urandom_range(0, 2))};
            set_now($urandom_range(0, 2), $urandom_range(0, 2),
                    $urandom_range(0, 2), $urandom_range(0, 2));
            tick_1hz = ($urandom_range(0, 1) == 0);
            flag_clr = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
        end
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0; flag_clr = 2'b00;
        repeat (2) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule